// File: doc/BRIEF.md
# Digital Loopback Mixer with Stepped Attenuation

This block adds captured converter-input samples, after a programmable digital attenuation, into the stereo playback stream bound for the output converters. Each channel takes one signed 16-bit capture sample and one signed 16-bit playback sample per valid strobe. It produces one registered, saturated 16-bit mix per channel one clock later, together with its own valid strobe.

Two 8-bit control registers govern the mix. The main register holds the loopback enable and a 6-bit attenuation code in 1.5 dB steps. The right-channel register holds a split flag and a second 6-bit code. With the split flag clear, the main code sets both channels. With it set, the main code sets only the left channel and the second code sets the right. The single enable gates loopback on both channels whatever the split flag says.

The attenuation gain for a code c is round(32768 · 10^(-1.5·c/20)), an unsigned Q1.15 value computed when the design is elaborated. The captured sample is multiplied by this gain and rounded back to 16 bits. It is then added to the playback sample, and the sum is clamped to the signed 16-bit range.

Top module: `lpbk_mix_top`

## Requirements
- R1: While reset is asserted, and after it, until the first valid input, out_vld is 0, out_l and out_r are 0, and both control registers read 0.
- R2: out_vld equals in_vld delayed by exactly one clock. out_l and out_r change only at the clock edge that samples in_vld = 1, and they hold their value otherwise.
- R3: With the enable (main register bit 0) at 0, out_l and out_r equal pb_l and pb_r exactly.
- R4: With the enable at 1, each output is sat16(pb + att), where att = floor((cap · gain + 16384) / 32768).
- R5: The gain for code c is round(32768 · 10^(-0.075·c)). Code 0 gives unity, so capture passes without error, including -32768. Code 63 gives gain 1.
- R6: With the split flag (right register bit 0) at 0, the code in main register bits 7:2 attenuates both channels, and right register bits 7:2 have no effect.
- R7: With the split flag at 1, main register bits 7:2 attenuate only the left channel, and right register bits 7:2 attenuate the right channel.
- R8: The enable bit alone switches loopback on both channels. With the split flag at 1 and the enable at 0, both channels pass playback unchanged.
- R9: A sum above 32767 outputs 32767, and a sum below -32768 outputs -32768.
- R10: Bit 1 of each register is reserved. Writes to it are ignored, and it always reads 0.
- R11: A write strobe stores the write data (apart from bit 1) into its register at the next clock edge. The register's content is visible on its readback port from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the main control register |
| cfg_wdata | input | 8 | Main register data: bit 0 enable, bit 1 reserved, bits 7:2 main code |
| rcfg_wr | input | 1 | Write strobe for the right-channel register |
| rcfg_wdata | input | 8 | Right register data: bit 0 split flag, bit 1 reserved, bits 7:2 right code |
| cfg_q | output | 8 | Main register contents |
| rcfg_q | output | 8 | Right register contents |
| in_vld | input | 1 | Input sample strobe |
| adc_l | input | 16 | Left capture sample, signed |
| adc_r | input | 16 | Right capture sample, signed |
| pb_l | input | 16 | Left playback sample, signed |
| pb_r | input | 16 | Right playback sample, signed |
| out_vld | output | 1 | Output sample strobe |
| out_l | output | 16 | Left mixed sample, signed |
| out_r | output | 16 | Right mixed sample, signed |

## Verification
The bench targets code routing under every combination of enable and split flag:
- A design that let the right code leak into the shared mode would fail the vector where the right register holds a non-zero code but the split flag is clear.
- A design that gated the right channel with the split flag instead of the enable would fail the split-set, enable-clear vector.

Full-scale capture at unity gain, and code 63 on a full-scale input, expose an off-by-one in the gain table or a missing rounding constant. A wrap-around instead of a clamp shows up as a sign flip on the two saturation cases. A reserved bit that gets stored shows up as 8'hFF reading back as 8'hFF instead of 8'hFD.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;

  // Elaboration-time gain: 2^frac * 10^(-code*step_mdb/20000), rounded.
  function automatic int unsigned gain_calc(int code, int frac, int step_mdb);
    real att_db;
    real lin;
    att_db = -(real'(code) * real'(step_mdb)) / 1000.0;
    lin    = $pow(10.0, att_db / 20.0) * $pow(2.0, real'(frac));
    return $rtoi(lin + 0.5);
  endfunction

  typedef enum logic [0:0] {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

endpackage

// File: rtl/lpbk_rst_sync.sv
module lpbk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_out = sh_q[STAGES-1];

endmodule

// File: rtl/lpbk_cfg_regs.sv
module lpbk_cfg_regs #(
  parameter int                REG_W    = 8,
  parameter logic [REG_W-1:0]  RSV_MASK = 'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);

  logic [REG_W-1:0] q_q;
  logic [REG_W-1:0] q_d;

  // Reserved positions are forced to zero on every write.
  always_comb begin
    q_d = wdata & ~RSV_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (wr_en) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/lpbk_gain_rom.sv
module lpbk_gain_rom #(
  parameter int CODE_W   = 6,
  parameter int FRAC_W   = 15,
  parameter int STEP_MDB = 1500
) (
  input  logic [CODE_W-1:0] code,
  output logic [FRAC_W:0]   gain
);

  localparam int DEPTH = 2 ** CODE_W;

  logic [FRAC_W:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int unsigned GI = lpbk_pkg::gain_calc(i, FRAC_W, STEP_MDB);
    assign tbl[i] = GI[FRAC_W:0];
  end

  assign gain = tbl[code];

endmodule

// File: rtl/lpbk_chan_mix.sv
module lpbk_chan_mix #(
  parameter int SMP_W  = 16,
  parameter int FRAC_W = 15
) (
  input  logic                    en,
  input  logic signed [SMP_W-1:0] cap,
  input  logic signed [SMP_W-1:0] pb,
  input  logic [FRAC_W:0]         gain,
  output logic signed [SMP_W-1:0] mix
);

  localparam int PW = SMP_W + FRAC_W + 2;
  localparam logic signed [PW-1:0] ONE  = PW'(1);
  localparam logic signed [PW-1:0] HALF = ONE <<< (FRAC_W - 1);
  localparam logic signed [PW-1:0] MAXV = (ONE <<< (SMP_W - 1)) - ONE;
  localparam logic signed [PW-1:0] MINV = -(ONE <<< (SMP_W - 1));

  logic signed [PW-1:0] cap_x;
  logic signed [PW-1:0] gain_x;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] att;
  logic signed [PW-1:0] pb_x;
  logic signed [PW-1:0] sum;

  always_comb begin
    cap_x  = PW'(cap);
    gain_x = $signed({{(PW-FRAC_W-1){1'b0}}, gain});
    prod   = cap_x * gain_x;
    att    = (prod + HALF) >>> FRAC_W;
    pb_x   = PW'(pb);
    sum    = pb_x + att;
    if (!en) begin
      mix = pb;
    end else if (sum > MAXV) begin
      mix = MAXV[SMP_W-1:0];
    end else if (sum < MINV) begin
      mix = MINV[SMP_W-1:0];
    end else begin
      mix = sum[SMP_W-1:0];
    end
  end

endmodule

// File: rtl/lpbk_mix_top.sv
module lpbk_mix_top #(
  parameter int SMP_W      = 16,
  parameter int CODE_W     = 6,
  parameter int FRAC_W     = 15,
  parameter int STEP_MDB   = 1500,
  parameter int RST_STAGES = 2,
  localparam int REG_W     = CODE_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [REG_W-1:0]        cfg_wdata,
  input  logic                    rcfg_wr,
  input  logic [REG_W-1:0]        rcfg_wdata,
  output logic [REG_W-1:0]        cfg_q,
  output logic [REG_W-1:0]        rcfg_q,
  input  logic                    in_vld,
  input  logic signed [SMP_W-1:0] adc_l,
  input  logic signed [SMP_W-1:0] adc_r,
  input  logic signed [SMP_W-1:0] pb_l,
  input  logic signed [SMP_W-1:0] pb_r,
  output logic                    out_vld,
  output logic signed [SMP_W-1:0] out_l,
  output logic signed [SMP_W-1:0] out_r
);

  import lpbk_pkg::*;

  localparam int NCH = 2;
  localparam logic [REG_W-1:0] RSV = REG_W'(2);

  logic rst_s_n;

  lpbk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s_n)
  );

  lpbk_cfg_regs #(.REG_W(REG_W), .RSV_MASK(RSV)) u_cfg_main (
    .clk   (clk),
    .rst_n (rst_s_n),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  lpbk_cfg_regs #(.REG_W(REG_W), .RSV_MASK(RSV)) u_cfg_right (
    .clk   (clk),
    .rst_n (rst_s_n),
    .wr_en (rcfg_wr),
    .wdata (rcfg_wdata),
    .q     (rcfg_q)
  );

  logic                    loop_en;
  logic                    split_en;
  logic [CODE_W-1:0]       code_a [NCH];
  logic [FRAC_W:0]         gain_a [NCH];
  logic signed [SMP_W-1:0] cap_a  [NCH];
  logic signed [SMP_W-1:0] pb_a   [NCH];
  logic signed [SMP_W-1:0] mix_a  [NCH];

  // Code routing: the main code always feeds left; right follows split flag.
  always_comb begin
    loop_en          = cfg_q[0];
    split_en         = rcfg_q[0];
    code_a[CH_LEFT]  = cfg_q[REG_W-1 -: CODE_W];
    code_a[CH_RIGHT] = split_en ? rcfg_q[REG_W-1 -: CODE_W]
                                : cfg_q[REG_W-1 -: CODE_W];
    cap_a[CH_LEFT]   = adc_l;
    cap_a[CH_RIGHT]  = adc_r;
    pb_a[CH_LEFT]    = pb_l;
    pb_a[CH_RIGHT]   = pb_r;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    lpbk_gain_rom #(
      .CODE_W   (CODE_W),
      .FRAC_W   (FRAC_W),
      .STEP_MDB (STEP_MDB)
    ) u_rom (
      .code (code_a[ch]),
      .gain (gain_a[ch])
    );

    lpbk_chan_mix #(
      .SMP_W  (SMP_W),
      .FRAC_W (FRAC_W)
    ) u_mix (
      .en   (loop_en),
      .cap  (cap_a[ch]),
      .pb   (pb_a[ch]),
      .gain (gain_a[ch]),
      .mix  (mix_a[ch])
    );
  end

  // Output stage: next state and registers kept apart.
  logic                    vld_d;
  logic                    vld_q;
  logic signed [SMP_W-1:0] out_d [NCH];
  logic signed [SMP_W-1:0] out_q [NCH];

  always_comb begin
    vld_d = in_vld;
    for (int ch = 0; ch < NCH; ch++) begin
      out_d[ch] = mix_a[ch];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        out_q[ch] <= '0;
      end
    end else if (in_vld) begin
      for (int ch = 0; ch < NCH; ch++) begin
        out_q[ch] <= out_d[ch];
      end
    end
  end

  assign out_vld = vld_q;
  assign out_l   = out_q[CH_LEFT];
  assign out_r   = out_q[CH_RIGHT];

endmodule

// File: rtl/lpbk_mix_chk.sv
module lpbk_mix_chk #(
  parameter int SMP_W = 16,
  parameter int REG_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_vld,
  input logic signed [SMP_W-1:0] adc_l,
  input logic signed [SMP_W-1:0] adc_r,
  input logic signed [SMP_W-1:0] pb_l,
  input logic signed [SMP_W-1:0] pb_r,
  input logic [REG_W-1:0]        cfg_q,
  input logic [REG_W-1:0]        rcfg_q,
  input logic                    out_vld,
  input logic signed [SMP_W-1:0] out_l,
  input logic signed [SMP_W-1:0] out_r
);

  AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld); // R2

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_l) && $stable(out_r))); // R2

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !cfg_q[0]) |=> (out_l == $past(pb_l) && out_r == $past(pb_r))); // R3

  AST_SILENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && adc_l == '0) |=> (out_l == $past(pb_l))); // R4

  AST_SHARED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !rcfg_q[0] && adc_l == adc_r && pb_l == pb_r) |=> (out_l == out_r)); // R6

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1] == 1'b0 && rcfg_q[1] == 1'b0)); // R10

endmodule

bind lpbk_mix_top lpbk_mix_chk #(.SMP_W(SMP_W), .REG_W(REG_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_s_n),
  .in_vld  (in_vld),
  .adc_l   (adc_l),
  .adc_r   (adc_r),
  .pb_l    (pb_l),
  .pb_r    (pb_r),
  .cfg_q   (cfg_q),
  .rcfg_q  (rcfg_q),
  .out_vld (out_vld),
  .out_l   (out_l),
  .out_r   (out_r)
);

// File: tb/lpbk_mix_top_test.sv
`timescale 1ns/1ps
module lpbk_mix_top_test;

  logic              clk;
  logic              rst_n;
  logic              cfg_wr;
  logic [7:0]        cfg_wdata;
  logic              rcfg_wr;
  logic [7:0]        rcfg_wdata;
  logic [7:0]        cfg_q;
  logic [7:0]        rcfg_q;
  logic              in_vld;
  logic signed [15:0] adc_l, adc_r, pb_l, pb_r;
  logic              out_vld;
  logic signed [15:0] out_l, out_r;

  lpbk_mix_top uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rcfg_wr(rcfg_wr), .rcfg_wdata(rcfg_wdata),
    .cfg_q(cfg_q), .rcfg_q(rcfg_q),
    .in_vld(in_vld), .adc_l(adc_l), .adc_r(adc_r), .pb_l(pb_l), .pb_r(pb_r),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [7:0]  cfg;
    logic [7:0]  rcfg;
    logic [15:0] al;
    logic [15:0] ar;
    logic [15:0] pl;
    logic [15:0] pr;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h00, 16'd1234,   -16'sd555,   16'd1000,   -16'sd2000},
    '{8'h01, 8'h00, 16'd1500,   -16'sd700,   16'd100,    16'd200},
    '{8'h11, 8'h00, 16'd10000,  -16'sd10000, 16'd0,      16'd0},
    '{8'hFD, 8'h00, 16'd32767,  -16'sd32768, 16'd5,      -16'sd5},
    '{8'h09, 8'h29, 16'd12000,  16'd12000,   16'd300,    16'd300},
    '{8'h08, 8'h29, 16'd9000,   -16'sd9000,  16'd77,     -16'sd88},
    '{8'h01, 8'h00, 16'd30000,  -16'sd30000, 16'd30000,  -16'sd30000},
    '{8'h0D, 8'h28, 16'd8000,   16'd8000,    -16'sd400,  -16'sd400},
    '{8'h05, 8'h00, -16'sd1,    16'd1,       16'd0,      16'd0},
    '{8'h41, 8'hC5, -16'sd20000, 16'd7777,   16'd5000,   -16'sd32768}
  };

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected mix from the requirements (R4, R5, R9).
  function automatic int model(bit en, int code, int cap, int pb);
    int    g;
    longint p, a, s;
    if (!en) return pb;
    g = $rtoi($pow(10.0, -0.075 * real'(code)) * 32768.0 + 0.5);
    p = longint'(cap) * longint'(g);
    a = (p + 64'sd16384) >>> 15;
    s = longint'(pb) + a;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return int'(s);
  endfunction

  function automatic string tag_of(logic [7:0] c, logic [7:0] r);
    if (!c[0]) return r[0] ? "R8" : "R3";
    return r[0] ? "R7" : "R6";
  endfunction

  task automatic wr_cfg(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_rcfg(logic [7:0] v);
    rcfg_wr = 1'b1; rcfg_wdata = v;
    @(negedge clk);
    rcfg_wr = 1'b0;
  endtask

  task automatic drive(logic signed [15:0] al, logic signed [15:0] ar,
                       logic signed [15:0] pl, logic signed [15:0] pr);
    adc_l = al; adc_r = ar; pb_l = pl; pb_r = pr; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; rcfg_wr = 1'b0; cfg_wdata = '0; rcfg_wdata = '0;
    in_vld = 1'b0; adc_l = '0; adc_r = '0; pb_l = '0; pb_r = '0;
    repeat (3) @(negedge clk);
    chk("R1", "out_vld in reset", int'(out_vld), 0);
    chk("R1", "out_l in reset", int'(out_l), 0);
    chk("R1", "cfg_q in reset", int'(cfg_q), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "out_r after reset", int'(out_r), 0);
    chk("R1", "rcfg_q after reset", int'(rcfg_q), 0);

    // Vector table walk.
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int   cl, cr;
      v = VECS[i];
      wr_cfg(v.cfg);
      wr_rcfg(v.rcfg);
      drive(v.al, v.ar, v.pl, v.pr);
      cl = int'(v.cfg[7:2]);
      cr = v.rcfg[0] ? int'(v.rcfg[7:2]) : cl;
      chk("R2", $sformatf("vec%0d out_vld", i), int'(out_vld), 1);
      chk(tag_of(v.cfg, v.rcfg), $sformatf("vec%0d left", i), int'(out_l),
          model(v.cfg[0], cl, int'($signed(v.al)), int'($signed(v.pl))));
      chk(tag_of(v.cfg, v.rcfg), $sformatf("vec%0d right", i), int'(out_r),
          model(v.cfg[0], cr, int'($signed(v.ar)), int'($signed(v.pr))));
    end

    // R2: no strobe, new inputs, outputs hold.
    begin
      int hl, hr;
      hl = int'(out_l); hr = int'(out_r);
      adc_l = 16'sd111; adc_r = 16'sd222; pb_l = 16'sd333; pb_r = 16'sd444;
      @(negedge clk);
      @(negedge clk);
      chk("R2", "out_vld idle", int'(out_vld), 0);
      chk("R2", "out_l hold", int'(out_l), hl);
      chk("R2", "out_r hold", int'(out_r), hr);
    end

    // R4: enabled mix with rounding, code 4.
    wr_rcfg(8'h00);
    wr_cfg(8'h11);
    drive(16'sd3333, -16'sd3333, 16'sd10, -16'sd10);
    chk("R4", "code4 left", int'(out_l), model(1'b1, 4, 3333, 10));
    chk("R4", "code4 right", int'(out_r), model(1'b1, 4, -3333, -10));

    // R5: unity at code 0 (full scale), gain 1 at code 63.
    wr_cfg(8'h01);
    drive(-16'sd32768, 16'sd32767, 16'sd0, 16'sd0);
    chk("R5", "code0 neg full scale", int'(out_l), -32768);
    chk("R5", "code0 pos full scale", int'(out_r), 32767);
    wr_cfg(8'hFD);
    drive(16'sd32767, -16'sd32768, 16'sd0, 16'sd0);
    chk("R5", "code63 pos", int'(out_l), 1);
    chk("R5", "code63 neg", int'(out_r), -1);

    // R9: clamps at both rails.
    wr_cfg(8'h01);
    drive(16'sd20000, -16'sd20000, 16'sd20000, -16'sd20000);
    chk("R9", "positive clamp", int'(out_l), 32767);
    chk("R9", "negative clamp", int'(out_r), -32768);

    // R10: reserved bit ignored, and a write of only that bit changes nothing.
    wr_cfg(8'hFF);
    chk("R10", "cfg reserved readback", int'(cfg_q), 8'hFD);
    wr_rcfg(8'h02);
    chk("R10", "rcfg reserved readback", int'(rcfg_q), 0);
    wr_cfg(8'h0D);
    drive(16'sd16000, 16'sd16000, 16'sd0, 16'sd0);
    chk("R10", "right uses main code", int'(out_r), model(1'b1, 3, 16000, 0));

    // R11: register write and readback.
    wr_cfg(8'h84);
    chk("R11", "cfg readback", int'(cfg_q), 8'h84);
    wr_rcfg(8'hA5);
    chk("R11", "rcfg readback", int'(rcfg_q), 8'hA5);

    // R1: reset in mid-run clears state.
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "out_l after mid reset", int'(out_l), 0);
    chk("R1", "cfg_q after mid reset", int'(cfg_q), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule